// File: doc/BRIEF.md
# Programmable Sync-Pattern Byte Receiver

This block is the receive front end of a byte-synchronous serial channel. It accepts one serial bit per cycle of a bit-rate enable and, while hunting, slides a window over the most recent bits looking for a sync word. The word is set by software and may be one to four bytes long. Once the word has been seen, the receiver counts byte boundaries from the bit that follows it and hands each completed byte to the next stage on a one-cycle valid strobe with an end-of-frame flag.

Fixed-length packets are supported through a terminal count. When it is enabled, the receiver flags the final byte of the packet as end of frame and then goes back to hunting without any help from software. When it is disabled, the receiver keeps delivering bytes until software issues a hunt command or turns the receiver off. A partial byte left when the receiver is pulled back to hunt is thrown away.

The sync word sits in the low bytes of a 32-bit pattern input. A 32-bit control input selects the word length, the terminal-count enable and the packet length.

Top module: `sync_byte_rx`

## Requirements
- R1: After reset `hunting` is 1 and `out_valid` and `out_eof` are 0.
- R2: A bit is taken only in a cycle where `rx_en` and `bit_en` are both 1. Bits are received most significant first: the first bit of a data byte becomes `out_data[7]`. The first bit of the sync word is compared against bit 8N-1 of `pat_reg`, where N is the selected length in bytes.
- R3: `ctl_reg[18:17]` selects the sync word: 00 uses `pat_reg[7:0]`, 01 uses `[15:0]`, 10 uses `[23:0]` and 11 uses `[31:0]`. Pattern bits above the selected length are ignored.
- R4: A match is accepted only after at least 8N bits have been taken since hunting began. Bits received before a return to hunt never count toward a match.
- R5: The sync word is not delivered. The first byte delivered is made of the 8 bits that follow the last sync bit. `out_valid` is high for the single cycle after the clock edge that takes the byte's eighth bit.
- R6: With `ctl_reg[16]` = 0, the receiver stays out of hunt after sync, keeps delivering bytes and never raises `out_eof`.
- R7: With `ctl_reg[16]` = 1, byte number `ctl_reg[15:0]`+1 of a packet (counted from 1) carries `out_eof` = 1 together with `out_valid`, and `hunting` is 1 from that same cycle. A value of 0 gives a one-byte packet.
- R8: A `hunt_cmd` pulse returns the receiver to hunt on the next edge. It drops any partial byte and restarts the packet byte count.
- R9: While `rx_en` is 0, serial bits are ignored, the receiver is held in hunt and no byte is delivered.
- R10: `ctl_reg[31:19]` has no effect on behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; 0 holds the receiver in hunt |
| hunt_cmd | input | 1 | One-cycle command to return to hunt |
| bit_en | input | 1 | Bit-rate enable; one serial bit per high cycle |
| rx_bit | input | 1 | Serial data |
| pat_reg | input | 32 | Sync word, held in the low bytes |
| ctl_reg | input | 32 | [18:17] word length, [16] terminal-count enable, [15:0] packet length minus one |
| out_valid | output | 1 | One-cycle strobe for a completed data byte |
| out_data | output | 8 | Completed data byte |
| out_eof | output | 1 | Marks the last byte of a fixed-length packet |
| hunting | output | 1 | 1 while the receiver searches for the sync word |

## Verification
Each byte result is due exactly one cycle after the clock edge that takes its eighth bit. `out_eof` appears in that same cycle, and `hunting` rises in that same cycle when the packet ends. Leaving hunt after a match, and returning to hunt after `hunt_cmd` or `rx_en` = 0, both take effect one edge after the stimulus. The bench drives one bit every four clocks from the falling edge. A monitor on the falling edge captures every strobe, so each byte is seen in the cycle it is due, and the state of `hunting` is read two falling edges after the last bit. The test vectors cover all four word lengths, the terminal count enabled and disabled, reserved bits set, and bits still arriving after a packet ends. Directed tests cover the fill rule, pattern bits above the selected length, a hunt command in the middle of a byte, and the disable input.

// File: rtl/xs_pkg.sv
package xs_pkg;

   localparam int XS_BYTE_W = 8;

   // control word layout; positions are decoded by software
   typedef struct packed {
      logic [12:0] rsvd;
      logic [1:0]  len_sel;
      logic        tc_en;
      logic [15:0] tc_val;
   } xs_ctl_t;

endpackage

// File: rtl/xs_hunt.sv
module xs_hunt #(
   parameter int MAX_BYTES = 4,
   parameter int BYTE_W    = 8,
   localparam int SR_W     = MAX_BYTES * BYTE_W,
   localparam int FILL_W   = $clog2(SR_W + 1),
   localparam int SEL_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             shift_en,
   input  logic             bit_in,
   input  logic [SR_W-1:0]  pat,
   input  logic [SEL_W-1:0] len_sel,
   output logic             match
);

   logic [SR_W-1:0]      sr_q;
   logic [SR_W-1:0]      sr_nxt;
   logic [FILL_W-1:0]    fill_q;
   logic [MAX_BYTES-1:0] lane_hit;
   logic [MAX_BYTES-1:0] lane_full;

   assign sr_nxt = {sr_q[SR_W-2:0], bit_in};

   for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
      localparam int LW = BYTE_W * (g + 1);
      assign lane_hit[g]  = (sr_nxt[LW-1:0] == pat[LW-1:0]);
      assign lane_full[g] = (fill_q >= FILL_W'(LW - 1));
   end

   assign match = shift_en && lane_hit[len_sel] && lane_full[len_sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         fill_q <= '0;
      end else begin
         if (shift_en) sr_q <= sr_nxt;
         if (clr)
            fill_q <= '0;
         else if (shift_en && (fill_q != FILL_W'(SR_W)))
            fill_q <= fill_q + 1'b1;
      end
   end

endmodule

// File: rtl/xs_byte_asm.sv
module xs_byte_asm #(
   parameter int BYTE_W = 8,
   localparam int CNT_W = $clog2(BYTE_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic              last_bit,
   output logic [BYTE_W-1:0] byte_nxt
);

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;

   assign byte_nxt = {sh_q[BYTE_W-2:0], bit_in};
   assign last_bit = shift_en && (cnt_q == CNT_W'(BYTE_W - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sh_q  <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (shift_en) begin
         cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
         sh_q  <= byte_nxt;
      end
   end

endmodule

// File: rtl/xs_frame_cnt.sv
module xs_frame_cnt #(
   parameter int TC_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            byte_done,
   input  logic            tc_en,
   input  logic [TC_W-1:0] tc_val,
   output logic            is_last
);

   logic [TC_W-1:0] cnt_q;

   assign is_last = tc_en && (cnt_q == tc_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (byte_done)
         cnt_q <= is_last ? '0 : cnt_q + 1'b1;
   end

endmodule

// File: rtl/sync_byte_rx.sv
module sync_byte_rx #(
   parameter int MAX_BYTES = 4,
   parameter int TC_W      = 16,
   localparam int BYTE_W   = xs_pkg::XS_BYTE_W,
   localparam int PAT_W    = MAX_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_en,
   input  logic              hunt_cmd,
   input  logic              bit_en,
   input  logic              rx_bit,
   input  logic [31:0]       pat_reg,
   input  logic [31:0]       ctl_reg,
   output logic              out_valid,
   output logic [BYTE_W-1:0] out_data,
   output logic              out_eof,
   output logic              hunting
);

   if (PAT_W != 32) begin : g_bad_width
      $error("sync_byte_rx: MAX_BYTES must give a 32-bit pattern");
   end
   if (TC_W != 16) begin : g_bad_tc
      $error("sync_byte_rx: TC_W must match the control field");
   end

   xs_pkg::xs_ctl_t ctl;
   assign ctl = xs_pkg::xs_ctl_t'(ctl_reg);

   logic force_hunt;
   logic bit_ok;
   logic match;
   logic byte_done;
   logic is_last;
   logic [BYTE_W-1:0] byte_nxt;

   assign force_hunt = !rx_en || hunt_cmd;
   assign bit_ok     = rx_en && bit_en;

   xs_hunt #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W)) u_hunt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (force_hunt || !hunting),
      .shift_en (bit_ok),
      .bit_in   (rx_bit),
      .pat      (pat_reg[PAT_W-1:0]),
      .len_sel  (ctl.len_sel),
      .match    (match)
   );

   xs_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (force_hunt || hunting),
      .shift_en (bit_ok && !hunting),
      .bit_in   (rx_bit),
      .last_bit (byte_done),
      .byte_nxt (byte_nxt)
   );

   xs_frame_cnt #(.TC_W(TC_W)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (force_hunt || hunting),
      .byte_done (byte_done),
      .tc_en     (ctl.tc_en),
      .tc_val    (ctl.tc_val),
      .is_last   (is_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hunting   <= 1'b1;
         out_valid <= 1'b0;
         out_eof   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= !force_hunt && byte_done;
         out_eof   <= !force_hunt && byte_done && is_last;
         if (byte_done) out_data <= byte_nxt;
         if (force_hunt)
            hunting <= 1'b1;
         else if (hunting && match)
            hunting <= 1'b0;
         else if (!hunting && byte_done && is_last)
            hunting <= 1'b1;
      end
   end

endmodule

// File: rtl/xs_chk.sv
module xs_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rx_en,
   input logic        hunt_cmd,
   input logic [31:0] ctl_reg,
   input logic        out_valid,
   input logic        out_eof,
   input logic        hunting
);

   // R7
   eof_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> out_valid);

   // R7
   eof_rehunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_eof |-> hunting);

   // R5
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R5
   valid_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !$past(hunting));

   // R6
   no_eof_untimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !$past(ctl_reg[16])) |-> !out_eof);

   // R8
   hunt_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_cmd |=> (hunting && !out_valid));

   // R9
   rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (hunting && !out_valid));

endmodule

bind sync_byte_rx xs_chk u_xs_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rx_en     (rx_en),
   .hunt_cmd  (hunt_cmd),
   .ctl_reg   (ctl_reg),
   .out_valid (out_valid),
   .out_eof   (out_eof),
   .hunting   (hunting)
);

// File: tb/sync_byte_rx_bench.sv
module sync_byte_rx_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 100000;

   typedef struct packed {
      logic [31:0] pat;
      logic [31:0] ctl;
      logic [31:0] pay;
      logic [3:0]  pay_n;
      logic [3:0]  exp_n;
      logic [3:0]  pat_n;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{32'h0000007E, 32'h00010001, 32'h0000A53C, 4'd2, 4'd2, 4'd1}, // R3 len 1, R7 two bytes
      '{32'h0000EB90, 32'h00030002, 32'h00123456, 4'd3, 4'd3, 4'd2}, // R3 len 2, R7
      '{32'h00C3A55A, 32'h00050000, 32'h0000F00F, 4'd2, 4'd1, 4'd3}, // R7 one-byte packet
      '{32'h1ACFFC1D, 32'h00070003, 32'hDEADBEEF, 4'd4, 4'd4, 4'd4}, // R3 len 4
      '{32'h00000096, 32'h00000000, 32'h00001122, 4'd2, 4'd2, 4'd1}, // R6 no terminal count
      '{32'h0000007E, 32'hFFF90000, 32'h000055AA, 4'd2, 4'd1, 4'd1}  // R10 reserved bits set
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_en = 1'b1;
   logic        hunt_cmd = 1'b0;
   logic        bit_en = 1'b0;
   logic        rx_bit = 1'b0;
   logic [31:0] pat_reg = '0;
   logic [31:0] ctl_reg = '0;
   logic        out_valid;
   logic [7:0]  out_data;
   logic        out_eof;
   logic        hunting;

   int n_chk = 0;
   int n_fail = 0;
   int rx_n = 0;
   logic [7:0] rx_data [16];
   logic       rx_eof  [16];

   always #(CLK_PERIOD / 2) clk = ~clk;

   sync_byte_rx u_sync_byte_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_en     (rx_en),
      .hunt_cmd  (hunt_cmd),
      .bit_en    (bit_en),
      .rx_bit    (rx_bit),
      .pat_reg   (pat_reg),
      .ctl_reg   (ctl_reg),
      .out_valid (out_valid),
      .out_data  (out_data),
      .out_eof   (out_eof),
      .hunting   (hunting)
   );

   always @(negedge clk) begin
      if (rst_n && out_valid && rx_n < 16) begin
         rx_data[rx_n] <= out_data;
         rx_eof[rx_n]  <= out_eof;
         rx_n          <= rx_n + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      rx_bit = b;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
      rx_bit = ~b;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic send_bits(input logic [31:0] w, input int nbits);
      for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic pulse_hunt();
      @(negedge clk);
      hunt_cmd = 1'b1;
      @(negedge clk);
      hunt_cmd = 1'b0;
      @(negedge clk);
      rx_n = 0;
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 hunting", 32'(hunting), 32'd1);
      check("R1 valid", 32'(out_valid), 32'd0);
      check("R1 eof", 32'(out_eof), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // vector table: R2 R3 R5 R6 R7 R10
      for (int v = 0; v < NV; v++) begin
         pat_reg = VEC[v].pat;
         ctl_reg = VEC[v].ctl;
         pulse_hunt();
         send_bits(VEC[v].pat, 8 * int'(VEC[v].pat_n));
         check("R5 synced after pattern", 32'(hunting), 32'd0);
         check("R5 sync word not delivered", 32'(rx_n), 32'd0);
         send_bits(VEC[v].pay, 8 * int'(VEC[v].pay_n));
         check("R7 byte count", 32'(rx_n), 32'(VEC[v].exp_n));
         for (int i = 0; i < int'(VEC[v].exp_n); i++) begin
            check("R2 data byte", 32'(rx_data[i]),
                  32'(VEC[v].pay[8 * (int'(VEC[v].pay_n) - 1 - i) +: 8]));
            check("R7 eof flag", 32'(rx_eof[i]),
                  32'(VEC[v].ctl[16] && (i == int'(VEC[v].exp_n) - 1)));
         end
         check("R6 hunt state at end", 32'(hunting), 32'(VEC[v].ctl[16]));
      end

      // R4 fill: stale zero history must not give an early match
      pat_reg = 32'h0;
      ctl_reg = 32'h0;
      pulse_hunt();
      send_bits(32'h0, 7);
      check("R4 seven bits not enough", 32'(hunting), 32'd1);
      send_bit(1'b0);
      check("R4 eighth bit syncs", 32'(hunting), 32'd0);

      // R3 pattern bits above the selected length are ignored
      pat_reg = 32'h0000EB90;
      ctl_reg = 32'h0;
      pulse_hunt();
      send_bits(32'h90, 8);
      check("R3 one-byte word uses low byte", 32'(hunting), 32'd0);
      ctl_reg = 32'h00020000;
      pulse_hunt();
      send_bits(32'h90, 8);
      check("R3 two-byte word needs both bytes", 32'(hunting), 32'd1);

      // R8 hunt command mid-byte drops the residue
      pat_reg = 32'h7E;
      ctl_reg = 32'h0;
      pulse_hunt();
      send_bits(32'h7E, 8);
      send_bits(32'h15, 5);
      pulse_hunt();
      check("R8 back in hunt", 32'(hunting), 32'd1);
      send_bits(32'h7, 3);
      check("R8 residue dropped", 32'(rx_n), 32'd0);

      // R8 hunt command restarts the packet byte count
      ctl_reg = 32'h00010001;
      pulse_hunt();
      send_bits(32'h7E, 8);
      send_bits(32'h11, 8);
      @(negedge clk);
      hunt_cmd = 1'b1;
      @(negedge clk);
      hunt_cmd = 1'b0;
      send_bits(32'h7E, 8);
      send_bits(32'h2233, 16);
      check("R8 bytes after restart", 32'(rx_n), 32'd3);
      check("R8 no eof on first byte after restart", 32'(rx_eof[1]), 32'd0);
      check("R8 eof on second byte after restart", 32'(rx_eof[2]), 32'd1);
      check("R8 data after restart", 32'(rx_data[2]), 32'h33);

      // R9 receiver disabled
      ctl_reg = 32'h0;
      pulse_hunt();
      rx_en = 1'b0;
      send_bits(32'h7E, 8);
      check("R9 disabled stays in hunt", 32'(hunting), 32'd1);
      rx_en = 1'b1;
      send_bits(32'h7E, 8);
      check("R9 enabled syncs", 32'(hunting), 32'd0);
      send_bits(32'hF, 4);
      @(negedge clk);
      rx_en = 1'b0;
      @(negedge clk);
      rx_en = 1'b1;
      @(negedge clk);
      check("R9 disable forces hunt", 32'(hunting), 32'd1);
      send_bits(32'hF, 4);
      check("R9 no byte delivered", 32'(rx_n), 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule